// File: doc/BRIEF.md
# Indexed Peripheral Clock Controller

This block holds the clock configuration for a set of peripherals (48 by default, up to 64) behind one command register. Each write to that register carries a peripheral index, a command bit and the configuration fields. With the command bit set, the write commits the fields to the addressed peripheral's entry. With the command bit clear, the write only points the readback at that peripheral. A read of the command register returns the configuration of the last index written.

Two pairs of read-only status words show which peripheral clocks and which generic clocks are running, one bit per peripheral. The outputs are per-peripheral enable strobes and the per-peripheral generic clock source and divider fields. Those outputs drive clock gating cells and divider datapaths that sit outside this block.

The register port is plain: one write per cycle, and reads are combinational from the read address. There is no stream traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `idx_clk_ctrl`

## Requirements
- R1: A write to address 0 with bit 7 set is a commit. It stores bit 8 (peripheral clock enable), bit 9 (generic clock enable), bits 14:12 (source select) and bits 23:16 (divider, value N meaning divide by N+1) into the entry indexed by bits 5:0. The stored fields appear on the outputs in the cycle after the write edge.
- R2: A write to address 0 with bit 7 clear changes no stored configuration or output. It only selects the index for readback.
- R3: A read of address 0 returns the selected index in bits 5:0, bit 7 as 0, and that entry's enable, generic-enable, source and divider in the same bit positions as a write. Every write to address 0 sets the selected index, whether or not it is a commit.
- R4: A commit with the enable bit clear drops that peripheral's enable output at the commit edge. There is no drain delay.
- R5: After reset, every enable output, every source and divider output, every status bit and the selected index read as zero.
- R6: A commit to an entry whose peripheral clock is enabled at the commit edge keeps the old source and divider. It still applies both enable bits.
- R7: The status words are registered copies of the enable outputs, one edge later. Address 1 holds peripheral clock status for indices 0–31 and address 2 for indices 32–63. Address 3 holds generic clock status for indices 0–31 and address 4 for indices 32–63.
- R8: A commit to an index at or above the peripheral count changes nothing. A readback of such an index returns zero configuration, with only the index field set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock enables |
| gclk_en | output | NUM_PERIPH | Generic clock enables |
| gclk_src | output | NUM_PERIPH*3 | Generic clock source per peripheral |
| gclk_div | output | NUM_PERIPH*8 | Generic clock divider field per peripheral |

## Verification
The bench commits new source and divider values to an entry while that entry is enabled, and again in the same commit that disables it. A design that checked the new enable instead of the stored one would let the divider change under a running clock. It sends select-only writes that carry nonzero fields; a design that ignored the command bit would overwrite the entry. It samples status one cycle after a commit, where a combinational status would already show the change. It commits and reads back an index above the peripheral count, which exposes aliasing onto a low entry or stale readback data.

// File: rtl/idxclk_pkg.sv
package idxclk_pkg;
  localparam int IDX_W  = 6;
  localparam int SRC_W  = 3;
  localparam int DIV_W  = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int STAT_WORDS = 2;
  localparam int STAT_W = STAT_WORDS * DATA_W;

  localparam logic [ADDR_W-1:0] A_CMD     = 3'd0;
  localparam logic [ADDR_W-1:0] A_PST_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PST_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GST_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_GST_HI  = 3'd4;

  localparam int F_IDX = 0;
  localparam int F_CMD = 7;
  localparam int F_PEN = 8;
  localparam int F_GEN = 9;
  localparam int F_SRC = 12;
  localparam int F_DIV = 16;

  typedef struct packed {
    logic             pen;
    logic             gen;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } pcfg_t;
endpackage

// File: rtl/idxclk_cmd_decode.sv
module idxclk_cmd_decode
  import idxclk_pkg::*;
#(
  parameter int NUM_PERIPH = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output pcfg_t             commit_cfg,
  output logic [IDX_W-1:0]  sel_idx
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_PERIPH);

  logic             cmd_hit;
  logic             idx_ok;
  logic [IDX_W-1:0] idx_field;

  assign cmd_hit   = wr_en && (wr_addr == A_CMD);
  assign idx_field = wr_data[F_IDX +: IDX_W];
  assign idx_ok    = {1'b0, idx_field} < LIMIT;

  assign commit     = cmd_hit && wr_data[F_CMD] && idx_ok;
  assign commit_idx = idx_field;

  always_comb begin
    commit_cfg     = '0;
    commit_cfg.pen = wr_data[F_PEN];
    commit_cfg.gen = wr_data[F_GEN];
    commit_cfg.src = wr_data[F_SRC +: SRC_W];
    commit_cfg.div = wr_data[F_DIV +: DIV_W];
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[DATA_W-1:F_DIV+DIV_W], wr_data[F_DIV-1:F_SRC+SRC_W],
                         wr_data[F_SRC-1:F_GEN+1], wr_data[F_CMD-1:F_IDX+IDX_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_idx <= '0;
    else if (cmd_hit) sel_idx <= idx_field;
  end
endmodule

// File: rtl/idxclk_cfg_bank.sv
module idxclk_cfg_bank
  import idxclk_pkg::*;
#(
  parameter int NUM_PERIPH = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [IDX_W-1:0]       commit_idx,
  input  pcfg_t                  commit_cfg,
  output pcfg_t [NUM_PERIPH-1:0] cfg
);
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_entry
    logic hit;
    assign hit = commit && (commit_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[i] <= '0;
      end else if (hit) begin
        cfg[i].pen <= commit_cfg.pen;
        cfg[i].gen <= commit_cfg.gen;
        if (!cfg[i].pen) begin
          cfg[i].src <= commit_cfg.src;
          cfg[i].div <= commit_cfg.div;
        end
      end
    end
  end
endmodule

// File: rtl/idxclk_status.sv
module idxclk_status
  import idxclk_pkg::*;
#(
  parameter int NUM_PERIPH = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] pen_vec,
  input  logic [NUM_PERIPH-1:0] gen_vec,
  output logic [STAT_W-1:0]     pen_stat,
  output logic [STAT_W-1:0]     gen_stat
);
  for (genvar j = 0; j < STAT_W; j++) begin : g_bit
    if (j < NUM_PERIPH) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pen_stat[j] <= 1'b0;
          gen_stat[j] <= 1'b0;
        end else begin
          pen_stat[j] <= pen_vec[j];
          gen_stat[j] <= gen_vec[j];
        end
      end
    end else begin : g_pad
      assign pen_stat[j] = 1'b0;
      assign gen_stat[j] = 1'b0;
    end
  end
endmodule

// File: rtl/idxclk_readback.sv
module idxclk_readback
  import idxclk_pkg::*;
#(
  parameter int NUM_PERIPH = 48
) (
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [IDX_W-1:0]       sel_idx,
  input  pcfg_t [NUM_PERIPH-1:0] cfg,
  input  logic [STAT_W-1:0]      pen_stat,
  input  logic [STAT_W-1:0]      gen_stat,
  output logic [DATA_W-1:0]      rd_data
);
  pcfg_t sel_cfg;

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (sel_idx == IDX_W'(i)) sel_cfg = cfg[i];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CMD: begin
        rd_data[F_IDX +: IDX_W] = sel_idx;
        rd_data[F_PEN]          = sel_cfg.pen;
        rd_data[F_GEN]          = sel_cfg.gen;
        rd_data[F_SRC +: SRC_W] = sel_cfg.src;
        rd_data[F_DIV +: DIV_W] = sel_cfg.div;
      end
      A_PST_LO: rd_data = pen_stat[0 +: DATA_W];
      A_PST_HI: rd_data = pen_stat[DATA_W +: DATA_W];
      A_GST_LO: rd_data = gen_stat[0 +: DATA_W];
      A_GST_HI: rd_data = gen_stat[DATA_W +: DATA_W];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/idx_clk_ctrl.sv
module idx_clk_ctrl
  import idxclk_pkg::*;
#(
  parameter int NUM_PERIPH = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_PERIPH-1:0]       periph_clk_en,
  output logic [NUM_PERIPH-1:0]       gclk_en,
  output logic [NUM_PERIPH*SRC_W-1:0] gclk_src,
  output logic [NUM_PERIPH*DIV_W-1:0] gclk_div
);
  logic                   commit;
  logic [IDX_W-1:0]       commit_idx;
  pcfg_t                  commit_cfg;
  logic [IDX_W-1:0]       sel_idx;
  pcfg_t [NUM_PERIPH-1:0] cfg;
  logic [STAT_W-1:0]      pen_stat;
  logic [STAT_W-1:0]      gen_stat;

  idxclk_cmd_decode #(.NUM_PERIPH(NUM_PERIPH)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_idx(commit_idx), .commit_cfg(commit_cfg), .sel_idx(sel_idx)
  );

  idxclk_cfg_bank #(.NUM_PERIPH(NUM_PERIPH)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_idx(commit_idx),
    .commit_cfg(commit_cfg), .cfg(cfg)
  );

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_out
    assign periph_clk_en[i]             = cfg[i].pen;
    assign gclk_en[i]                   = cfg[i].gen;
    assign gclk_src[i*SRC_W +: SRC_W]   = cfg[i].src;
    assign gclk_div[i*DIV_W +: DIV_W]   = cfg[i].div;
  end

  idxclk_status #(.NUM_PERIPH(NUM_PERIPH)) u_stat (
    .clk(clk), .rst_n(rst_n), .pen_vec(periph_clk_en), .gen_vec(gclk_en),
    .pen_stat(pen_stat), .gen_stat(gen_stat)
  );

  idxclk_readback #(.NUM_PERIPH(NUM_PERIPH)) u_rd (
    .rd_addr(rd_addr), .sel_idx(sel_idx), .cfg(cfg),
    .pen_stat(pen_stat), .gen_stat(gen_stat), .rd_data(rd_data)
  );
endmodule

// File: rtl/idx_clk_ctrl_chk.sv
module idx_clk_ctrl_chk
  import idxclk_pkg::*;
#(
  parameter int NUM_PERIPH = 48
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [DATA_W-1:0]           wr_data,
  input logic [NUM_PERIPH-1:0]       periph_clk_en,
  input logic [NUM_PERIPH-1:0]       gclk_en,
  input logic [NUM_PERIPH*SRC_W-1:0] gclk_src,
  input logic [NUM_PERIPH*DIV_W-1:0] gclk_div,
  input logic [STAT_W-1:0]           pen_stat,
  input logic [STAT_W-1:0]           gen_stat
);
  logic             cmd_w;
  logic [IDX_W-1:0] w_idx;
  logic             w_inside;

  assign cmd_w    = wr_en && (wr_addr == A_CMD);
  assign w_idx    = wr_data[F_IDX +: IDX_W];
  assign w_inside = 32'(w_idx) < NUM_PERIPH;

  // R2: select-only write leaves every output as it was
  a_r2_select_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && !wr_data[F_CMD]) |=> ($stable(periph_clk_en) && $stable(gclk_en) &&
                                    $stable(gclk_src) && $stable(gclk_div)));

  // R8: commit outside the implemented range leaves every output as it was
  a_r8_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[F_CMD] && !w_inside) |=> ($stable(periph_clk_en) && $stable(gclk_en) &&
                                                $stable(gclk_src) && $stable(gclk_div)));

  // R6: source and divider locked while the peripheral clock runs
  a_r6_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[F_CMD] && w_inside && periph_clk_en[w_idx]) |=>
      ($stable(gclk_src) && $stable(gclk_div)));

  // R4: a commit clearing the enable stops it at once
  a_r4_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[F_CMD] && w_inside && !wr_data[F_PEN]) |=> !periph_clk_en[$past(w_idx)]);

  // R7: status words trail the enables by one edge
  a_r7_pen_status: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pen_stat[NUM_PERIPH-1:0] == $past(periph_clk_en)));
  a_r7_gen_status: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (gen_stat[NUM_PERIPH-1:0] == $past(gclk_en)));
endmodule

bind idx_clk_ctrl idx_clk_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .periph_clk_en(periph_clk_en), .gclk_en(gclk_en), .gclk_src(gclk_src),
  .gclk_div(gclk_div), .pen_stat(pen_stat), .gen_stat(gen_stat)
);

// File: tb/idx_clk_ctrl_tb.sv
module idx_clk_ctrl_tb;
  localparam int NUM = 48;
  localparam int NV  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [2:0]        rd_addr = '0;
  logic [31:0]       rd_data;
  logic [NUM-1:0]    periph_clk_en;
  logic [NUM-1:0]    gclk_en;
  logic [NUM*3-1:0]  gclk_src;
  logic [NUM*8-1:0]  gclk_div;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  idx_clk_ctrl #(.NUM_PERIPH(NUM)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .periph_clk_en(periph_clk_en),
    .gclk_en(gclk_en), .gclk_src(gclk_src), .gclk_div(gclk_div)
  );

  function automatic logic [31:0] enc(int idx, bit cmd, bit pen, bit gen, int src, int dv);
    logic [31:0] w;
    w = '0;
    w[5:0]   = 6'(idx);
    w[7]     = cmd;
    w[8]     = pen;
    w[9]     = gen;
    w[14:12] = 3'(src);
    w[23:16] = 8'(dv);
    return w;
  endfunction

  // {write word, expected readback of the same index}
  localparam logic [63:0] TBL [NV] = '{
    {enc(3, 1, 0, 1, 5, 8'h10), enc(3, 0, 0, 1, 5, 8'h10)},
    {enc(3, 1, 1, 1, 5, 8'h10), enc(3, 0, 1, 1, 5, 8'h10)},
    {enc(3, 1, 1, 0, 2, 8'h22), enc(3, 0, 1, 0, 5, 8'h10)},
    {enc(3, 0, 0, 0, 7, 8'hFF), enc(3, 0, 1, 0, 5, 8'h10)},
    {enc(3, 1, 0, 0, 2, 8'h22), enc(3, 0, 0, 0, 5, 8'h10)},
    {enc(3, 1, 0, 1, 2, 8'h22), enc(3, 0, 0, 1, 2, 8'h22)},
    {enc(40, 1, 1, 1, 6, 8'h80), enc(40, 0, 1, 1, 6, 8'h80)},
    {enc(47, 1, 1, 0, 1, 8'h01), enc(47, 0, 1, 0, 1, 8'h01)},
    {enc(50, 1, 1, 1, 3, 8'h03), enc(50, 0, 0, 0, 0, 8'h00)},
    {enc(0, 1, 1, 1, 7, 8'hFF), enc(0, 0, 1, 1, 7, 8'hFF)}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int idx;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5 enables", 32'(|periph_clk_en | |gclk_en), 32'd0);
    chk("R5 src/div", 32'(|gclk_src | |gclk_div), 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      chk($sformatf("R5 read addr %0d", a), r, 32'd0);
    end
    rst_n = 1'b1;

    // table: R1 R3 with R2, R6, R8 rows
    for (int v = 0; v < NV; v++) begin
      wr(TBL[v][63:32]);
      idx = int'(TBL[v][37:32]);
      wr(enc(idx, 0, 0, 0, 0, 0));
      rd(3'd0, r);
      chk($sformatf("R1 R3 vector %0d readback", v), r, TBL[v][31:0]);
      if (idx < NUM)
        chk($sformatf("R1 vector %0d enable out", v), 32'(periph_clk_en[idx]), 32'(TBL[v][8]));
    end

    // R7 status words after the table
    rd(3'd1, r); chk("R7 pclk status lo", r, 32'h0000_0001);
    rd(3'd2, r); chk("R7 pclk status hi", r, 32'h0000_8100);
    rd(3'd3, r); chk("R7 gclk status lo", r, 32'h0000_0009);
    rd(3'd4, r); chk("R7 gclk status hi", r, 32'h0000_0100);
    chk("R1 divider out idx3", 32'(gclk_div[3*8 +: 8]), 32'h22);
    chk("R1 source out idx3", 32'(gclk_src[3*3 +: 3]), 32'd2);

    // R7 / R4 timing on index 10
    wr(enc(10, 1, 1, 0, 0, 0));
    chk("R1 enable at commit edge", 32'(periph_clk_en[10]), 32'd1);
    rd(3'd1, r); chk("R7 status lags one edge", 32'(r[10]), 32'd0);
    @(negedge clk);
    rd(3'd1, r); chk("R7 status after one edge", 32'(r[10]), 32'd1);
    wr(enc(10, 1, 0, 0, 0, 0));
    chk("R4 enable drops at commit edge", 32'(periph_clk_en[10]), 32'd0);
    rd(3'd1, r); chk("R7 status holds one edge", 32'(r[10]), 32'd1);
    @(negedge clk);
    rd(3'd1, r); chk("R7 status clears", 32'(r[10]), 32'd0);

    // R6 directed: enabled entry keeps source/divider, takes gen enable
    wr(enc(20, 1, 1, 0, 1, 8'h05));
    wr(enc(20, 1, 1, 1, 4, 8'h44));
    chk("R6 source held", 32'(gclk_src[20*3 +: 3]), 32'd1);
    chk("R6 divider held", 32'(gclk_div[20*8 +: 8]), 32'h05);
    chk("R6 gen enable applied", 32'(gclk_en[20]), 32'd1);

    // R2 directed: select-only write with nonzero fields
    wr(enc(20, 0, 0, 0, 6, 8'h99));
    chk("R2 enable unchanged", 32'(periph_clk_en[20]), 32'd1);
    chk("R2 divider unchanged", 32'(gclk_div[20*8 +: 8]), 32'h05);
    rd(3'd0, r); chk("R3 select readback", r, enc(20, 0, 1, 1, 1, 8'h05));

    // R8 directed: out-of-range commit
    wr(enc(55, 1, 1, 1, 2, 8'h12));
    rd(3'd0, r); chk("R8 readback out of range", r, enc(55, 0, 0, 0, 0, 0));
    @(negedge clk);
    rd(3'd2, r); chk("R8 status hi unchanged", r, 32'h0000_8100);
    chk("R8 entry 55 mod 48 untouched", 32'(gclk_div[7*8 +: 8]), 32'h00);

    // R5 reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R5 enables after reset", 32'(|periph_clk_en | |gclk_en), 32'd0);
    rd(3'd0, r); chk("R5 readback after reset", r, 32'd0);
    rd(3'd2, r); chk("R5 status after reset", r, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule